// File: doc/BRIEF.md
# Branch Trace Record Writer

This block captures taken branches into a circular region of system memory. Each captured branch becomes one record of two 32-bit words: the source address first and the destination address second. The words go out one at a time through a simple write port with a request/ready handshake.

The memory window is set by a base address and an exclusive limit address. Two independent settings control capture:

- **Busy policy.** When the output path is busy, a new branch is either dropped, with a sticky loss indication, or the CPU is stalled until the pending record has drained.
- **Full policy.** When the window is full, the write position either wraps to the base and overwrites the oldest records, or capture stops for good while the program runs on.

A CPU pipeline or debug subsystem uses it by presenting one branch per cycle with a valid strobe. In stall mode the CPU must hold the branch while the stall output is high.

Top module: `brt_trace_writer`

## Requirements
- R1: While reset is held and directly after it, `mem_req_o`, `cpu_stall_o` and `rec_lost_o` are 0.
- R2: A record is written as two words. The first carries the branch source at the current write address. The second carries the destination at that address plus 4. A word is held stable on the port until the cycle in which `mem_ready_i` is 1.
- R3: The first record after reset is written at `cfg_base_i`. Each completed record advances the write address by 8 bytes. Every write address lies inside [base, limit-4].
- R4: With `cfg_stall_mode_i` = 0, a branch arriving while a record is still being written is discarded, and `cpu_stall_o` stays 0.
- R5: A discarded branch sets `rec_lost_o` in the following cycle. The flag then stays 1 until reset.
- R6: With `cfg_stall_mode_i` = 1, `cpu_stall_o` is 1 in every cycle in which a record is pending. A branch held by the CPU during that time is written later, and `rec_lost_o` stays 0.
- R7: With `cfg_stop_full_i` = 0, when the record just finished leaves less than 8 bytes before the limit, the next record is written at the base.
- R8: With `cfg_stop_full_i` = 1, once the window is full, no further write is issued. Later branches are ignored without stalling the CPU and without setting the loss flag.
- R9: A branch with `br_cond_i` = 1 and `br_zero_disp_i` = 1 is not recorded. `br_zero_disp_i` has no effect on a branch with `br_cond_i` = 0.
- R10: A window is rejected, and no capture takes place, in any of these cases:
  - the limit is below the base;
  - the window is smaller than one record;
  - the window is larger than `MAX_REGION_BYTES` (1 MB by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_valid_i | input | 1 | A branch is presented this cycle |
| br_cond_i | input | 1 | The branch is conditional |
| br_zero_disp_i | input | 1 | The branch displacement is zero |
| br_src_i | input | 32 | Branch source address |
| br_dst_i | input | 32 | Branch destination address |
| cfg_base_i | input | 32 | First byte of the trace window |
| cfg_limit_i | input | 32 | First byte past the trace window |
| cfg_stall_mode_i | input | 1 | 1: stall the CPU when busy; 0: drop |
| cfg_stop_full_i | input | 1 | 1: stop when full; 0: wrap and overwrite |
| mem_ready_i | input | 1 | The memory accepts the current word |
| mem_req_o | output | 1 | A word write is requested |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Word to be written |
| cpu_stall_o | output | 1 | Holds the CPU (stall mode only) |
| rec_lost_o | output | 1 | Sticky: a record was dropped |

## Verification
A branch sampled at a rising edge while the block is idle raises `mem_req_o` with the source word in the cycle that follows. Each word then moves on at the rising edge where `mem_ready_i` is high. The loss flag appears one cycle after the discarded branch, while the stall output follows the busy state within the same cycle. The bench advances a behavioural model at each rising edge from the same inputs and compares every output at the falling edge. Directed checks on the logged writes run only after a settling interval long enough for all pending records to drain.

// File: rtl/brt_pkg.sv
package brt_pkg;
   parameter int unsigned TR_AW = 32;
   localparam int unsigned TR_WORD_BYTES = TR_AW / 8;
   localparam int unsigned TR_REC_WORDS  = 2;
   localparam int unsigned TR_REC_BYTES  = TR_REC_WORDS * TR_WORD_BYTES;

   typedef enum logic [1:0] {
      BEAT_IDLE = 2'd0,
      BEAT_SRC  = 2'd1,
      BEAT_DST  = 2'd2
   } beat_e;

   typedef struct packed {
      logic [TR_AW-1:0] src;
      logic [TR_AW-1:0] dst;
   } trace_rec_t;
endpackage

// File: rtl/brt_region_check.sv
module brt_region_check #(
   parameter int unsigned AW        = 32,
   parameter int unsigned MAX_BYTES = 32'h0010_0000,
   parameter int unsigned REC_BYTES = 8
) (
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] limit_i,
   output logic          ok_o,
   output logic [AW-1:0] size_o
);
   logic ordered;
   logic holds_one;
   logic within_max;

   if (REC_BYTES == 0) begin : g_bad_rec
      $error("brt_region_check: REC_BYTES must be nonzero");
   end

   assign size_o    = limit_i - base_i;
   assign ordered   = (limit_i >= base_i);
   assign holds_one = (size_o >= AW'(REC_BYTES));

   if (MAX_BYTES == 0) begin : g_unbounded
      assign within_max = 1'b1;
   end else begin : g_bounded
      assign within_max = (size_o <= AW'(MAX_BYTES));
   end

   assign ok_o = ordered & holds_one & within_max;
endmodule

// File: rtl/brt_ptr.sv
module brt_ptr #(
   parameter int unsigned AW        = 32,
   parameter int unsigned REC_BYTES = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          advance_i,
   input  logic          stop_mode_i,
   input  logic          ok_i,
   input  logic [AW-1:0] size_i,
   output logic [AW-1:0] offset_o,
   output logic          full_o
);
   logic [AW-1:0] next_off;
   logic          no_room;

   assign next_off = offset_o + AW'(REC_BYTES);
   assign no_room  = ({1'b0, next_off} + (AW+1)'(REC_BYTES)) > {1'b0, size_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         offset_o <= '0;
         full_o   <= 1'b0;
      end else if (advance_i && ok_i) begin
         if (no_room) begin
            if (stop_mode_i) full_o <= 1'b1;
            else             offset_o <= '0;
         end else begin
            offset_o <= next_off;
         end
      end
   end

   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |=> full_o); // R8
   AST_OFF_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_i && !full_o) |-> (({1'b0, offset_o} + (AW+1)'(REC_BYTES)) <= {1'b0, size_i})); // R7
endmodule

// File: rtl/brt_beat_seq.sv
module brt_beat_seq #(
   parameter int unsigned AW = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take_i,
   input  brt_pkg::trace_rec_t rec_i,
   input  logic                ready_i,
   output logic                busy_o,
   output logic                second_o,
   output logic                req_o,
   output logic [AW-1:0]       wdata_o,
   output logic                done_o
);
   import brt_pkg::*;

   beat_e      state;
   trace_rec_t hold;

   if (AW != TR_AW) begin : g_bad_aw
      $error("brt_beat_seq: AW must equal the package word width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= BEAT_IDLE;
         hold  <= '0;
      end else begin
         case (state)
            BEAT_IDLE: if (take_i) begin
               hold  <= rec_i;
               state <= BEAT_SRC;
            end
            BEAT_SRC:  if (ready_i) state <= BEAT_DST;
            BEAT_DST:  if (ready_i) state <= BEAT_IDLE;
            default:   state <= BEAT_IDLE;
         endcase
      end
   end

   assign busy_o   = (state != BEAT_IDLE);
   assign second_o = (state == BEAT_DST);
   assign req_o    = busy_o;
   assign wdata_o  = second_o ? hold.dst : hold.src;
   assign done_o   = second_o & ready_i;

   AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ready_i) |=> (req_o && $stable(wdata_o) && $stable(second_o))); // R2
   AST_SRC_THEN_DST: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !second_o && ready_i) |=> (req_o && second_o)); // R2
endmodule

// File: rtl/brt_trace_writer.sv
module brt_trace_writer #(
   parameter int unsigned ADDR_W           = 32,
   parameter int unsigned MAX_REGION_BYTES = 32'h0010_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              br_valid_i,
   input  logic              br_cond_i,
   input  logic              br_zero_disp_i,
   input  logic [ADDR_W-1:0] br_src_i,
   input  logic [ADDR_W-1:0] br_dst_i,
   input  logic [ADDR_W-1:0] cfg_base_i,
   input  logic [ADDR_W-1:0] cfg_limit_i,
   input  logic              cfg_stall_mode_i,
   input  logic              cfg_stop_full_i,
   input  logic              mem_ready_i,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [ADDR_W-1:0] mem_wdata_o,
   output logic              cpu_stall_o,
   output logic              rec_lost_o
);
   import brt_pkg::*;

   localparam int unsigned WORD_BYTES = ADDR_W / 8;
   localparam int unsigned REC_BYTES  = TR_REC_WORDS * WORD_BYTES;

   if (ADDR_W != TR_AW) begin : g_bad_width
      $error("brt_trace_writer: ADDR_W must equal the package word width");
   end
   if (MAX_REGION_BYTES != 0 && MAX_REGION_BYTES < REC_BYTES) begin : g_bad_max
      $error("brt_trace_writer: MAX_REGION_BYTES smaller than one record");
   end

   logic              win_ok;
   logic [ADDR_W-1:0] win_size;
   logic [ADDR_W-1:0] offset;
   logic              full;
   logic              busy;
   logic              second;
   logic              done;
   logic              skip_zero;
   logic              qualified;
   logic              take;
   logic              drop;
   trace_rec_t        rec_in;

   brt_region_check #(
      .AW(ADDR_W), .MAX_BYTES(MAX_REGION_BYTES), .REC_BYTES(REC_BYTES)
   ) u_region (
      .base_i (cfg_base_i),
      .limit_i(cfg_limit_i),
      .ok_o   (win_ok),
      .size_o (win_size)
   );

   assign skip_zero = br_cond_i & br_zero_disp_i;
   assign qualified = br_valid_i & win_ok & ~full & ~skip_zero;
   assign take      = qualified & ~busy;
   assign drop      = qualified & busy & ~cfg_stall_mode_i;
   assign rec_in    = '{src: br_src_i, dst: br_dst_i};

   brt_beat_seq #(.AW(ADDR_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_i  (take),
      .rec_i   (rec_in),
      .ready_i (mem_ready_i),
      .busy_o  (busy),
      .second_o(second),
      .req_o   (mem_req_o),
      .wdata_o (mem_wdata_o),
      .done_o  (done)
   );

   brt_ptr #(.AW(ADDR_W), .REC_BYTES(REC_BYTES)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .advance_i  (done),
      .stop_mode_i(cfg_stop_full_i),
      .ok_i       (win_ok),
      .size_i     (win_size),
      .offset_o   (offset),
      .full_o     (full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rec_lost_o <= 1'b0;
      else if (drop) rec_lost_o <= 1'b1;
   end

   assign cpu_stall_o = cfg_stall_mode_i & busy;
   assign mem_addr_o  = cfg_base_i + offset + (second ? ADDR_W'(WORD_BYTES) : '0);

   AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rec_lost_o |=> rec_lost_o); // R5
   AST_LOST_ONLY_RT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rec_lost_o) |-> !$past(cfg_stall_mode_i)); // R6
   AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (mem_addr_o >= cfg_base_i &&
                     ({1'b0, mem_addr_o} + (ADDR_W+1)'(WORD_BYTES)) <= {1'b0, cfg_limit_i})); // R3
   AST_NO_WRITE_BADCFG: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (cfg_limit_i >= cfg_base_i)); // R10
   AST_ZERO_DISP_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid_i && br_cond_i && br_zero_disp_i && !mem_req_o) |=> !mem_req_o); // R9
   AST_RT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !cfg_stall_mode_i) |-> !cpu_stall_o); // R4
endmodule

// File: tb/tb_brt_trace_writer.sv
`timescale 1ns/1ps
module tb_brt_trace_writer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        br_valid = 1'b0, br_cond = 1'b0, br_dz = 1'b0;
   logic [31:0] br_src = '0, br_dst = '0;
   logic [31:0] cfg_base = 32'h1000, cfg_limit = 32'h1040;
   logic        stall_mode = 1'b0, stop_full = 1'b0;
   logic        mem_ready = 1'b1;
   logic        mem_req, cpu_stall, rec_lost;
   logic [31:0] mem_addr, mem_wdata;

   int checks = 0, errors = 0;
   int rdy_per = 1;
   int cyc = 0;
   int wn = 0;
   int stall_seen = 0;
   logic [31:0] wa [0:63];
   logic [31:0] wd [0:63];

   int          m_state = 0;
   logic [31:0] m_src = '0, m_dst = '0, m_off = '0;
   bit          m_full = 1'b0, m_lost = 1'b0;

   always #2.5 clk = ~clk;

   brt_trace_writer dut (
      .clk(clk), .rst_n(rst_n),
      .br_valid_i(br_valid), .br_cond_i(br_cond), .br_zero_disp_i(br_dz),
      .br_src_i(br_src), .br_dst_i(br_dst),
      .cfg_base_i(cfg_base), .cfg_limit_i(cfg_limit),
      .cfg_stall_mode_i(stall_mode), .cfg_stop_full_i(stop_full),
      .mem_ready_i(mem_ready),
      .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
      .cpu_stall_o(cpu_stall), .rec_lost_o(rec_lost)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic bit win_ok();
      logic [31:0] sz;
      sz = cfg_limit - cfg_base;
      return (cfg_limit >= cfg_base) && (sz >= 32'd8) && (sz <= 32'h0010_0000);
   endfunction

   // behavioural reference, advanced on each rising edge
   always @(posedge clk) begin
      bit q;
      cyc++;
      if (!rst_n) begin
         m_state = 0; m_off = '0; m_full = 1'b0; m_lost = 1'b0;
      end else begin
         q = br_valid && win_ok() && !m_full && !(br_cond && br_dz);
         case (m_state)
            0: if (q) begin m_src = br_src; m_dst = br_dst; m_state = 1; end
            1: begin
               if (q && !stall_mode) m_lost = 1'b1;
               if (mem_ready) m_state = 2;
            end
            default: begin
               if (q && !stall_mode) m_lost = 1'b1;
               if (mem_ready) begin
                  m_state = 0;
                  m_off = m_off + 32'd8;
                  if (m_off + 32'd8 > cfg_limit - cfg_base) begin
                     if (stop_full) m_full = 1'b1;
                     else m_off = '0;
                  end
               end
            end
         endcase
      end
   end

   // write log
   always @(posedge clk) begin
      if (rst_n && mem_req && mem_ready && wn < 64) begin
         wa[wn] = mem_addr; wd[wn] = mem_wdata; wn++;
      end
   end

   // per-cycle comparison at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2", {31'd0, mem_req}, {31'd0, m_state != 0}, "mem_req");
         if (m_state != 0) begin
            chk("R3", mem_addr, cfg_base + m_off + ((m_state == 2) ? 32'd4 : 32'd0), "mem_addr");
            chk("R2", mem_wdata, (m_state == 2) ? m_dst : m_src, "mem_wdata");
         end
         chk(stall_mode ? "R6" : "R4", {31'd0, cpu_stall},
             {31'd0, stall_mode && m_state != 0}, "cpu_stall");
         chk("R5", {31'd0, rec_lost}, {31'd0, m_lost}, "rec_lost");
         if (cpu_stall) stall_seen++;
      end
   end

   always @(negedge clk) begin
      #1;
      mem_ready = (rdy_per <= 1) ? 1'b1 : ((cyc % rdy_per) == 0);
   end

   task automatic setup(logic [31:0] b, logic [31:0] l, logic sm, logic sf, int rp);
      @(negedge clk); #1;
      rst_n = 1'b0;
      cfg_base = b; cfg_limit = l; stall_mode = sm; stop_full = sf; rdy_per = rp;
      repeat (2) @(negedge clk);
      #1;
      rst_n = 1'b1;
      wn = 0; stall_seen = 0;
   endtask

   task automatic send(logic [31:0] s, logic [31:0] d, logic c, logic z);
      logic hold;
      @(negedge clk); #1;
      br_src = s; br_dst = d; br_cond = c; br_dz = z; br_valid = 1'b1;
      forever begin
         hold = cpu_stall;
         @(negedge clk); #1;
         if (!hold) break;
      end
      br_valid = 1'b0; br_cond = 1'b0; br_dz = 1'b0;
   endtask

   task automatic settle();
      repeat (30) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      chk("R1", {31'd0, mem_req}, 32'd0, "mem_req in reset");
      chk("R1", {31'd0, cpu_stall}, 32'd0, "cpu_stall in reset");
      chk("R1", {31'd0, rec_lost}, 32'd0, "rec_lost in reset");

      // R2/R3: basic records, realtime, memory always ready
      setup(32'h1000, 32'h1040, 1'b0, 1'b0, 1);
      @(negedge clk);
      chk("R1", {31'd0, mem_req}, 32'd0, "mem_req after reset");
      send(32'hA000_0010, 32'hA000_0100, 1'b0, 1'b0);
      settle();
      send(32'hA000_0020, 32'hA000_0200, 1'b1, 1'b0);
      settle();
      chk("R2", wn, 32'd4, "word count two records");
      chk("R3", wa[0], 32'h1000, "first word at base");
      chk("R2", wd[0], 32'hA000_0010, "first word is source");
      chk("R2", wa[1], 32'h1004, "second word address");
      chk("R2", wd[1], 32'hA000_0100, "second word is destination");
      chk("R3", wa[2], 32'h1008, "next record 8 bytes on");

      // R4/R5: realtime drop with slow memory
      setup(32'h1000, 32'h1040, 1'b0, 1'b0, 3);
      send(32'hB000_0000, 32'hB000_0100, 1'b0, 1'b0);
      send(32'hB000_0004, 32'hB000_0200, 1'b0, 1'b0);
      settle();
      chk("R4", wn, 32'd2, "second branch dropped");
      chk("R4", stall_seen, 32'd0, "no stall in realtime");
      chk("R5", {31'd0, rec_lost}, 32'd1, "lost flag set");
      settle();
      chk("R5", {31'd0, rec_lost}, 32'd1, "lost flag sticky");

      // R6: stall mode keeps every record
      setup(32'h1000, 32'h1040, 1'b1, 1'b0, 3);
      send(32'hC000_0000, 32'hC000_0100, 1'b0, 1'b0);
      send(32'hC000_0004, 32'hC000_0200, 1'b0, 1'b0);
      send(32'hC000_0008, 32'hC000_0300, 1'b0, 1'b0);
      settle();
      chk("R6", wn, 32'd6, "no record lost under stall");
      chk("R6", {31'd0, rec_lost}, 32'd0, "lost flag clear");
      chk("R6", {31'd0, stall_seen > 0}, 32'd1, "stall observed");
      chk("R6", wd[4], 32'hC000_0008, "held branch written");

      // R7: wrap in a three-record window
      setup(32'h2000, 32'h2018, 1'b0, 1'b0, 1);
      for (int i = 0; i < 4; i++) begin
         send(32'hD000_0000 + 32'(i), 32'hD100_0000 + 32'(i), 1'b0, 1'b0);
         settle();
      end
      chk("R7", wn, 32'd8, "four records written");
      chk("R7", wa[6], 32'h2000, "fourth record wraps to base");
      chk("R7", wd[6], 32'hD000_0003, "wrapped record source");

      // R8: stop when full
      setup(32'h2000, 32'h2018, 1'b0, 1'b1, 1);
      for (int i = 0; i < 5; i++) begin
         send(32'hE000_0000 + 32'(i), 32'hE100_0000 + 32'(i), 1'b0, 1'b0);
         settle();
      end
      chk("R8", wn, 32'd6, "capture stops after three records");
      chk("R8", {31'd0, mem_req}, 32'd0, "no request when full");
      chk("R8", {31'd0, rec_lost}, 32'd0, "ignored branches not counted lost");

      // R9: zero displacement conditional branches
      setup(32'h3000, 32'h3100, 1'b0, 1'b0, 1);
      send(32'hF000_0000, 32'hF000_0000, 1'b1, 1'b1);
      settle();
      chk("R9", wn, 32'd0, "conditional zero-disp skipped");
      send(32'hF000_0010, 32'hF000_0080, 1'b1, 1'b0);
      settle();
      chk("R9", wn, 32'd2, "conditional branch recorded");
      send(32'hF000_0020, 32'hF000_0020, 1'b0, 1'b1);
      settle();
      chk("R9", wn, 32'd4, "unconditional with zero flag recorded");
      chk("R9", wa[2], 32'h3008, "address after skipped branch");

      // R10: rejected windows
      setup(32'h5000, 32'h4000, 1'b0, 1'b0, 1);
      send(32'h1111_0000, 32'h2222_0000, 1'b0, 1'b0);
      settle();
      chk("R10", wn, 32'd0, "limit below base");
      setup(32'h0, 32'h0020_0000, 1'b0, 1'b0, 1);
      send(32'h1111_0004, 32'h2222_0004, 1'b0, 1'b0);
      settle();
      chk("R10", wn, 32'd0, "window above maximum");
      setup(32'h6000, 32'h6004, 1'b0, 1'b0, 1);
      send(32'h1111_0008, 32'h2222_0008, 1'b0, 1'b0);
      settle();
      chk("R10", wn, 32'd0, "window below one record");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule